// File: doc/BRIEF.md
# Interface Identifier to Unit Number Translator

This block performs the translation stage of an extension-dispatch scheme. Software supplies a source word whose upper bits name an extension interface and whose low 12 bits pick which implementation of that interface is wanted (zero meaning the default one). The block matches that identifier, the device number and the caller's current privilege level against a small associative table programmed at configuration time. It returns a result word: the 12-bit logical unit number of the matching device in the low bits, with the low part of a second operand packed above it.

When nothing in the table matches at the caller's privilege level, the block does not merely raise a miss flag. It returns a fallback unit number chosen by a variant select, and every bit from 12 upward is zero. Unit 0 makes later commands trap, unit 1 makes them return zero, and unit 2 makes them return minus one. Units 3 to 31 are reserved, so configured devices use unit numbers from 32 upward. The translation keeps no state between requests and never changes the table.

A lookup is combinational over the table. Its result is captured in the clock cycle after a request pulse and is flagged by a response-valid strobe. Table entries are written through a single indexed write port.

Top module: `xlt_translator`

## Requirements
- R1: On a hit, result bits 11:0 hold the unit number of the entry and result bits XLEN-1:12 hold bits XLEN-13:0 of the second operand. The top 12 bits of that operand are discarded.
- R2: On a miss, the result is 0 for variant 2'b00 (trap), 1 for variant 2'b01 (return zero), 2 for variant 2'b10 (return minus one) and 0 for the unused code 2'b11. All result bits from 12 upward are zero.
- R3: An entry matches only if its 4-bit privilege tag equals the current level, which is one-hot: user 0001, supervisor 0010, hypervisor 0100, machine 1000.
- R4: An entry matches only if its identifier equals source bits XLEN-1:12 and its device number equals source bits 11:0. Device number 0 is an ordinary key value that selects the default implementation.
- R5: When several valid entries match, the entry with the lowest index supplies the unit number.
- R6: An entry written with its valid bit clear never matches.
- R7: The response-valid output is high for exactly the one cycle after each cycle in which request-valid is high. Between requests, the result output holds its last value.
- R8: A table write and a lookup in the same cycle give a lookup result based on the table contents from before that write.
- R9: After reset, response-valid is low, the result is zero and every table entry is invalid, so every lookup returns its fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(DEPTH) | Index of the entry to write |
| tbl_valid | input | 1 | Valid bit of the written entry |
| tbl_ident | input | XLEN-12 | Interface identifier of the written entry |
| tbl_dev | input | 12 | Device sequence number of the written entry |
| tbl_priv | input | 4 | Privilege tag of the written entry |
| tbl_unit | input | 12 | Unit number of the written entry |
| req_valid | input | 1 | Lookup request pulse |
| req_src | input | XLEN | Identifier (upper bits) and device number (bits 11:0) |
| req_opnd | input | XLEN | Second operand supplying the data bits |
| req_priv | input | 4 | Current privilege level, one-hot |
| req_variant | input | 2 | Fallback variant select |
| rsp_valid | output | 1 | Result valid strobe |
| rsp_result | output | XLEN | Unit number and data bits, or fallback |

## Verification
The hardest case to reach from the ports is a lookup where several valid entries hold the same identifier and device number but differ in privilege tag or index. Only there do priority order and privilege filtering show a difference. The stimulus therefore draws identifiers and device numbers from a small pool of four and three values and rewrites random entries often. This produces frequent duplicate and near-duplicate keys. Directed cases add a lookup issued in the same cycle as a write to the entry that would match.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int LUN_W  = 12;
  localparam int DEV_W  = 12;
  localparam int PRIV_W = 4;

  localparam logic [1:0] VAR_TRAP = 2'b00;
  localparam logic [1:0] VAR_ZERO = 2'b01;
  localparam logic [1:0] VAR_MONE = 2'b10;

  // Unit number returned when the lookup finds no entry.
  function automatic logic [LUN_W-1:0] fallback_unit(input logic [1:0] variant);
    case (variant)
      VAR_ZERO: fallback_unit = LUN_W'(1);
      VAR_MONE: fallback_unit = LUN_W'(2);
      default:  fallback_unit = '0;
    endcase
  endfunction
endpackage

// File: rtl/xlt_table.sv
module xlt_table
  import xlt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ID_W  = 20,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [IDX_W-1:0]              idx,
  input  logic                          w_valid,
  input  logic [ID_W-1:0]               w_ident,
  input  logic [DEV_W-1:0]              w_dev,
  input  logic [PRIV_W-1:0]             w_priv,
  input  logic [LUN_W-1:0]              w_unit,
  output logic [DEPTH-1:0]              e_valid,
  output logic [DEPTH-1:0][ID_W-1:0]    e_ident,
  output logic [DEPTH-1:0][DEV_W-1:0]   e_dev,
  output logic [DEPTH-1:0][PRIV_W-1:0]  e_priv,
  output logic [DEPTH-1:0][LUN_W-1:0]   e_unit
);
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) begin
          e_valid[g] <= 1'b0;
        end else if (we && (idx == IDX_W'(g))) begin
          e_valid[g] <= w_valid;
        end
      end

      // Key and payload fields need no reset; validity gates their use.
      always_ff @(posedge clk) begin
        if (we && (idx == IDX_W'(g))) begin
          e_ident[g] <= w_ident;
          e_dev[g]   <= w_dev;
          e_priv[g]  <= w_priv;
          e_unit[g]  <= w_unit;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xlt_match.sv
module xlt_match
  import xlt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ID_W  = 20
) (
  input  logic [DEPTH-1:0]              e_valid,
  input  logic [DEPTH-1:0][ID_W-1:0]    e_ident,
  input  logic [DEPTH-1:0][DEV_W-1:0]   e_dev,
  input  logic [DEPTH-1:0][PRIV_W-1:0]  e_priv,
  input  logic [DEPTH-1:0][LUN_W-1:0]   e_unit,
  input  logic [ID_W-1:0]               k_ident,
  input  logic [DEV_W-1:0]              k_dev,
  input  logic [PRIV_W-1:0]             k_priv,
  output logic                          hit,
  output logic [LUN_W-1:0]              unit
);
  logic [DEPTH-1:0] hv;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign hv[g] = e_valid[g] && (e_ident[g] == k_ident) &&
                     (e_dev[g] == k_dev) && (e_priv[g] == k_priv);
    end
  endgenerate

  // Scan from the top down so the lowest matching index is the last one kept.
  always_comb begin
    unit = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hv[i]) unit = e_unit[i];
    end
  end

  assign hit = |hv;
endmodule

// File: rtl/xlt_format.sv
module xlt_format
  import xlt_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             hit,
  input  logic [LUN_W-1:0] unit,
  input  logic [XLEN-1:0]  opnd,
  input  logic [1:0]       variant,
  output logic [XLEN-1:0]  result
);
  always_comb begin
    if (hit) result = {opnd[XLEN-LUN_W-1:0], unit};
    else     result = {{(XLEN-LUN_W){1'b0}}, fallback_unit(variant)};
  end
endmodule

// File: rtl/xlt_translator.sv
module xlt_translator
  import xlt_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DEPTH = 16,
  localparam int ID_W  = XLEN - DEV_W,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic              tbl_valid,
  input  logic [ID_W-1:0]   tbl_ident,
  input  logic [DEV_W-1:0]  tbl_dev,
  input  logic [PRIV_W-1:0] tbl_priv,
  input  logic [LUN_W-1:0]  tbl_unit,
  input  logic              req_valid,
  input  logic [XLEN-1:0]   req_src,
  input  logic [XLEN-1:0]   req_opnd,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic [1:0]        req_variant,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   rsp_result
);
  logic [DEPTH-1:0]              e_valid;
  logic [DEPTH-1:0][ID_W-1:0]    e_ident;
  logic [DEPTH-1:0][DEV_W-1:0]   e_dev;
  logic [DEPTH-1:0][PRIV_W-1:0]  e_priv;
  logic [DEPTH-1:0][LUN_W-1:0]   e_unit;
  logic                          lk_hit;
  logic [LUN_W-1:0]              lk_unit;
  logic [XLEN-1:0]               lk_result;

  xlt_table #(.DEPTH(DEPTH), .ID_W(ID_W)) u_table (
    .clk(clk), .rst(rst), .we(tbl_we), .idx(tbl_idx), .w_valid(tbl_valid),
    .w_ident(tbl_ident), .w_dev(tbl_dev), .w_priv(tbl_priv), .w_unit(tbl_unit),
    .e_valid(e_valid), .e_ident(e_ident), .e_dev(e_dev), .e_priv(e_priv),
    .e_unit(e_unit)
  );

  xlt_match #(.DEPTH(DEPTH), .ID_W(ID_W)) u_match (
    .e_valid(e_valid), .e_ident(e_ident), .e_dev(e_dev), .e_priv(e_priv),
    .e_unit(e_unit), .k_ident(req_src[XLEN-1:DEV_W]), .k_dev(req_src[DEV_W-1:0]),
    .k_priv(req_priv), .hit(lk_hit), .unit(lk_unit)
  );

  xlt_format #(.XLEN(XLEN)) u_format (
    .hit(lk_hit), .unit(lk_unit), .opnd(req_opnd), .variant(req_variant),
    .result(lk_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_result <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_result <= lk_result;
    end
  end
endmodule

// File: rtl/xlt_translator_chk.sv
module xlt_translator_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [XLEN-1:0] req_opnd,
  input logic [1:0]      req_variant,
  input logic            lk_hit,
  input logic            rsp_valid,
  input logic [XLEN-1:0] rsp_result
);
  function automatic logic [XLEN-1:0] miss_word(input logic [1:0] v);
    miss_word = (v == 2'b01) ? XLEN'(1) : (v == 2'b10) ? XLEN'(2) : '0;
  endfunction

  // R7: response strobe follows each request by one cycle
  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid)) |-> rsp_valid);
  assert_rsp_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(req_valid)) |-> !rsp_valid);
  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(req_valid)) |-> $stable(rsp_result));
  // R1: data bits come from the second operand on a hit
  assert_hit_data_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && lk_hit)) |->
      (rsp_result[XLEN-1:12] == $past(req_opnd[XLEN-13:0])));
  // R2: miss returns the variant's fallback with upper bits clear
  assert_miss_fallback_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !lk_hit)) |->
      (rsp_result == miss_word($past(req_variant))));
endmodule

bind xlt_translator xlt_translator_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_opnd(req_opnd),
  .req_variant(req_variant), .lk_hit(lk_hit), .rsp_valid(rsp_valid),
  .rsp_result(rsp_result)
);

// File: tb/xlt_translator_tb.sv
module xlt_translator_tb;
  localparam int PERIOD = 10;
  localparam int XLEN   = 32;
  localparam int DEPTH  = 16;
  localparam int ID_W   = XLEN - 12;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam logic [3:0] PU = 4'b0001, PS = 4'b0010, PH = 4'b0100, PM = 4'b1000;

  logic clk = 1'b0;
  logic rst;
  logic tbl_we, tbl_valid, req_valid;
  logic [IDX_W-1:0] tbl_idx;
  logic [ID_W-1:0] tbl_ident;
  logic [11:0] tbl_dev, tbl_unit;
  logic [3:0] tbl_priv, req_priv;
  logic [XLEN-1:0] req_src, req_opnd, rsp_result;
  logic [1:0] req_variant;
  logic rsp_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // Bench model of the table, maintained from the writes the bench issues.
  bit              m_v[DEPTH];
  logic [ID_W-1:0] m_id[DEPTH];
  logic [11:0]     m_dev[DEPTH];
  logic [3:0]      m_pr[DEPTH];
  logic [11:0]     m_un[DEPTH];
  logic [XLEN-1:0] last_res;

  always #(PERIOD/2) clk = ~clk;

  xlt_translator #(.XLEN(XLEN), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
    .tbl_ident(tbl_ident), .tbl_dev(tbl_dev), .tbl_priv(tbl_priv), .tbl_unit(tbl_unit),
    .req_valid(req_valid), .req_src(req_src), .req_opnd(req_opnd), .req_priv(req_priv),
    .req_variant(req_variant), .rsp_valid(rsp_valid), .rsp_result(rsp_result)
  );

  function automatic logic [XLEN-1:0] expect_res(input logic [XLEN-1:0] src,
      input logic [XLEN-1:0] op, input logic [3:0] pr, input logic [1:0] v);
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[i] && m_id[i] == src[XLEN-1:12] && m_dev[i] == src[11:0] && m_pr[i] == pr)
        return {op[XLEN-13:0], m_un[i]};
    end
    return (v == 2'b01) ? XLEN'(1) : (v == 2'b10) ? XLEN'(2) : XLEN'(0);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: optional write and optional lookup, driven together at a negedge.
  task automatic step(input bit dw, input int idx, input bit v, input logic [ID_W-1:0] id,
      input logic [11:0] dev, input logic [3:0] wp, input logic [11:0] un,
      input bit dr, input logic [XLEN-1:0] src, input logic [XLEN-1:0] op,
      input logic [3:0] rp, input logic [1:0] var_sel, input string tag);
    logic [XLEN-1:0] exp;
    @(negedge clk);
    tbl_we = dw; tbl_idx = IDX_W'(idx); tbl_valid = v; tbl_ident = id;
    tbl_dev = dev; tbl_priv = wp; tbl_unit = un;
    req_valid = dr; req_src = src; req_opnd = op; req_priv = rp; req_variant = var_sel;
    exp = dr ? expect_res(src, op, rp, var_sel) : last_res;
    if (dw) begin
      m_v[idx] = v; m_id[idx] = id; m_dev[idx] = dev; m_pr[idx] = wp; m_un[idx] = un;
    end
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    check(rsp_valid == dr, {tag, " R7 valid"}, XLEN'(rsp_valid), XLEN'(dr));
    check(rsp_result == exp, tag, rsp_result, exp);
    last_res = exp;
  endtask

  task automatic wr(input int idx, input bit v, input logic [ID_W-1:0] id,
      input logic [11:0] dev, input logic [3:0] p, input logic [11:0] un);
    step(1'b1, idx, v, id, dev, p, un, 1'b0, '0, '0, PU, 2'b00, "write");
  endtask

  task automatic lk(input logic [XLEN-1:0] src, input logic [XLEN-1:0] op,
      input logic [3:0] p, input logic [1:0] v, input string tag);
    step(1'b0, 0, 1'b0, '0, '0, PU, '0, 1'b1, src, op, p, v, tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [ID_W-1:0] pool [4];
    void'($urandom(32'd2024));
    pool[0] = 20'h12345; pool[1] = 20'hABCDE; pool[2] = 20'h00001; pool[3] = 20'h00002;
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 0; m_id[i] = '0; m_dev[i] = '0; m_pr[i] = '0; m_un[i] = '0;
    end
    last_res = '0;
    rst = 1'b1; tbl_we = 0; tbl_idx = '0; tbl_valid = 0; tbl_ident = '0; tbl_dev = '0;
    tbl_priv = '0; tbl_unit = '0; req_valid = 0; req_src = '0; req_opnd = '0;
    req_priv = PU; req_variant = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state and empty table
    check(rsp_valid == 1'b0, "R9 valid after reset", XLEN'(rsp_valid), '0);
    check(rsp_result == '0, "R9 result after reset", rsp_result, '0);
    lk({20'h12345, 12'h000}, 32'hFFFF_FFFF, PU, 2'b10, "R9 empty table miss");

    // R1/R4: hit with default device 0, and with a nonzero device
    wr(0, 1, 20'h12345, 12'h000, PU, 12'd32);
    wr(1, 1, 20'h12345, 12'h001, PU, 12'd33);
    lk({20'h12345, 12'h000}, 32'hABC1_2345, PU, 2'b00, "R1 hit default device");
    lk({20'h12345, 12'h001}, 32'h0000_0FFF, PU, 2'b00, "R4 hit device 1");
    lk({20'h12345, 12'h002}, 32'h1234_5678, PU, 2'b01, "R4 device mismatch miss");
    lk({20'h12346, 12'h000}, 32'h1234_5678, PU, 2'b00, "R4 identifier mismatch miss");
    // R3: privilege must be equal
    lk({20'h12345, 12'h000}, 32'h5555_5555, PS, 2'b10, "R3 wrong privilege miss");
    wr(2, 1, 20'h12345, 12'h000, PM, 12'd40);
    lk({20'h12345, 12'h000}, 32'h5555_5555, PM, 2'b00, "R3 machine entry hit");
    // R2: all four variants on a miss
    for (int v = 0; v < 4; v++)
      lk({20'hBEEF0, 12'h003}, 32'hFFFF_FFFF, PH, 2'(v), "R2 miss variant");
    // R5: duplicate key, lower index wins
    wr(5, 1, 20'hABCDE, 12'h000, PS, 12'd50);
    wr(3, 1, 20'hABCDE, 12'h000, PS, 12'd51);
    lk({20'hABCDE, 12'h000}, 32'h0F0F_0F0F, PS, 2'b00, "R5 lowest index wins");
    // R6: invalidated entry stops matching; higher duplicate then wins
    wr(3, 0, 20'hABCDE, 12'h000, PS, 12'd51);
    lk({20'hABCDE, 12'h000}, 32'h0F0F_0F0F, PS, 2'b00, "R6 invalid entry skipped");
    // R7: idle cycles keep the result and keep valid low
    step(0, 0, 0, '0, '0, PU, '0, 0, '0, '0, PU, 2'b00, "R7 hold idle 1");
    step(0, 0, 0, '0, '0, PU, '0, 0, '0, '0, PU, 2'b00, "R7 hold idle 2");
    // R8: same-cycle write sees the old table, both directions
    step(1, 4, 1, 20'h00777, 12'h005, PH, 12'd60,
         1, {20'h00777, 12'h005}, 32'h2222_2222, PH, 2'b01, "R8 write-new lookup old");
    lk({20'h00777, 12'h005}, 32'h2222_2222, PH, 2'b01, "R8 new entry now hits");
    step(1, 4, 0, 20'h00777, 12'h005, PH, 12'd60,
         1, {20'h00777, 12'h005}, 32'h3333_3333, PH, 2'b01, "R8 invalidate lookup old");
    lk({20'h00777, 12'h005}, 32'h3333_3333, PH, 2'b10, "R8 invalidated now misses");

    // Random mix: small key pool so duplicates and near-misses are common
    for (int n = 0; n < 600; n++) begin
      logic [3:0] rp;
      rp = 4'b0001 << ($urandom % 4);
      if ($urandom % 3 == 0)
        wr(int'($urandom % DEPTH), ($urandom % 8) != 0, pool[$urandom % 4],
           12'($urandom % 3), 4'b0001 << ($urandom % 4), 12'(32 + $urandom % 64));
      else if ($urandom % 4 == 0)
        step(0, 0, 0, '0, '0, PU, '0, 0, '0, '0, PU, 2'b00, "R7 random idle");
      else
        lk({pool[$urandom % 4], 12'($urandom % 3)}, $urandom, rp, 2'($urandom % 4),
           "R1 R2 R3 R5 random lookup");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule